// File: doc/BRIEF.md
# Condition-Code ALU

This block is the arithmetic/logic stage of a small register-to-register instruction set. Two operands arrive from the register file. `op_a` comes from the source register field and `op_b` comes from the destination register field. A 4-bit function code picks one of four operations. The result is purely combinational, so a write-back stage can capture it in the same cycle. Write-back itself is outside this block.

Beside the datapath sits a three-bit condition-code register holding zero, sign and overflow. The decode stage raises `set_cc` only for operate-class instructions. On the next rising clock edge the flags take the values that describe the current result. At any other time the flags keep their value, so moves, branches and other instructions leave them untouched. Conditional moves and branches downstream read the flags.

The reset input is asynchronous and active low. Its release is synchronised inside the block. After reset the flags read as zero set, sign clear and overflow clear.

Top module: `cc_alu`

## Requirements
- R1: Function code 0 gives `result = op_b + op_a`, modulo 2^WIDTH.
- R2: Function code 1 gives `result = op_b - op_a`, modulo 2^WIDTH. The operand from the destination register is the minuend.
- R3: Function code 2 gives the bitwise AND of the operands. Function code 3 gives the bitwise XOR.
- R4: For function codes 4 to 15, `illegal` is 1 and `result` is all zeros. For codes 0 to 3, `illegal` is 0.
- R5: When `set_cc` is 1 and the code is legal, the next rising edge sets `zf` to 1 exactly when `result` is zero.
- R6: On the same kind of update, `sf` takes bit WIDTH-1 of `result`.
- R7: On the same kind of update, `of` is set as follows:
  - For add, `of` is 1 when both operands share a sign that the result does not have.
  - For subtract, `of` is 1 when the operand signs differ and the result sign differs from `op_b`.
  - For AND and XOR, `of` is 0.
- R8: While `set_cc` is 0, all three flags keep their value across clock edges.
- R9: An illegal function code with `set_cc` at 1 leaves all three flags unchanged.
- R10: After reset, `zf` is 1, `sf` is 0 and `of` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_a | input | WIDTH | Operand from the source register |
| op_b | input | WIDTH | Operand from the destination register (minuend for subtract) |
| fn_code | input | 4 | Function select: 0 add, 1 subtract, 2 AND, 3 XOR |
| set_cc | input | 1 | High for operate-class instructions; allows a flag update |
| result | output | WIDTH | Combinational result |
| illegal | output | 1 | High when fn_code is above 3 |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| of | output | 1 | Two's-complement overflow flag |

## Verification
A 4-bit copy of the block is swept over every operand pair with all sixteen function codes, and `set_cc` is varied across the sweep.

- The sweep reaches every signed-overflow boundary of add and subtract. This separates the correct sign rules from a mistaken operand order or a wrong carry.
- It mixes legal and illegal codes, with the update enable both on and off. This tells a proper hold apart from a flag register that updates on the wrong condition.

A 64-bit copy is then driven with extreme values, such as the most negative number minus one and zero minus the most negative number. These confirm that the sign bit is taken from the top of the full word.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic zero;
    logic sign;
    logic ovf;
  } cc_t;

  localparam cc_t CC_RESET = '{zero: 1'b1, sign: 1'b0, ovf: 1'b0};
endpackage

// File: rtl/cc_alu_rst_sync.sv
module cc_alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cc_alu_addsub.sv
module cc_alu_addsub #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             do_sub,
  output logic [WIDTH-1:0] sum,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] a_eff;

  // One carry chain serves both: b + a, or b + ~a + 1.
  always_comb begin
    a_eff = do_sub ? ~opnd_a : opnd_a;
    sum   = opnd_b + a_eff + {{(WIDTH-1){1'b0}}, do_sub};
    ovf   = (opnd_b[MSB] == a_eff[MSB]) && (sum[MSB] != opnd_b[MSB]);
  end
endmodule

// File: rtl/cc_alu_flags.sv
module cc_alu_flags #(
  parameter int WIDTH = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_en,
  input  logic [WIDTH-1:0]    value,
  input  logic                ovf_in,
  output cc_alu_pkg::cc_t     cc
);
  import cc_alu_pkg::*;

  cc_t cc_q, cc_d;

  always_comb begin
    cc_d = cc_q;
    if (upd_en) begin
      cc_d.zero = (value == '0);
      cc_d.sign = value[WIDTH-1];
      cc_d.ovf  = ovf_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cc_q <= CC_RESET;
    else        cc_q <= cc_d;
  end

  assign cc = cc_q;
endmodule

// File: rtl/cc_alu.sv
module cc_alu #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       fn_code,
  input  logic             set_cc,
  output logic [WIDTH-1:0] result,
  output logic             illegal,
  output logic             zf,
  output logic             sf,
  output logic             of
);
  import cc_alu_pkg::*;

  logic             rst_sync_n;
  logic             legal;
  alu_op_e          op_sel;
  logic [WIDTH-1:0] arith_res;
  logic             arith_ovf;
  logic             ovf_sel;
  cc_t              cc;

  cc_alu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign legal  = (fn_code[3:2] == 2'b00);
  assign op_sel = alu_op_e'(fn_code[1:0]);

  cc_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .opnd_a (op_a),
    .opnd_b (op_b),
    .do_sub (op_sel == OP_SUB),
    .sum    (arith_res),
    .ovf    (arith_ovf)
  );

  always_comb begin
    result  = '0;
    ovf_sel = 1'b0;
    if (legal) begin
      unique case (op_sel)
        OP_ADD, OP_SUB: begin
          result  = arith_res;
          ovf_sel = arith_ovf;
        end
        OP_AND: result = op_b & op_a;
        OP_XOR: result = op_b ^ op_a;
      endcase
    end
  end

  cc_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .upd_en (set_cc && legal),
    .value  (result),
    .ovf_in (ovf_sel),
    .cc     (cc)
  );

  assign illegal = !legal;
  assign zf      = cc.zero;
  assign sf      = cc.sign;
  assign of      = cc.ovf;
endmodule

// File: rtl/cc_alu_checker.sv
module cc_alu_checker #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [3:0]       fn_code,
  input logic             set_cc,
  input logic [WIDTH-1:0] result,
  input logic             illegal,
  input logic             zf,
  input logic             sf,
  input logic             of
);
  a_r4_illegal_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    illegal |-> (result == '0));

  a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (set_cc && !illegal) |=> (zf == ($past(result) == '0)));

  a_r6_sign_flag: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (set_cc && !illegal) |=> (sf == $past(result[WIDTH-1])));

  a_r7_add_ovf: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (set_cc && fn_code == 4'd0) |=>
      (of == (($past(op_a[WIDTH-1]) == $past(op_b[WIDTH-1])) &&
              ($past(result[WIDTH-1]) != $past(op_a[WIDTH-1])))));

  a_r7_logic_no_ovf: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (set_cc && (fn_code == 4'd2 || fn_code == 4'd3)) |=> !of);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !set_cc |=> ($stable(zf) && $stable(sf) && $stable(of)));

  a_r9_illegal_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    illegal |=> ($stable(zf) && $stable(sf) && $stable(of)));
endmodule

bind cc_alu cc_alu_checker #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .op_a       (op_a),
  .op_b       (op_b),
  .fn_code    (fn_code),
  .set_cc     (set_cc),
  .result     (result),
  .illegal    (illegal),
  .zf         (zf),
  .sf         (sf),
  .of         (of)
);

// File: tb/test_cc_alu.sv
module test_cc_alu;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int WW = 64;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NW-1:0] na, nb, nres;
  logic [3:0]    nfn;
  logic          nset, nill, nzf, nsf, nof;

  logic [WW-1:0] wa, wb, wres;
  logic [3:0]    wfn;
  logic          wset, will, wzf, wsf, wof;

  cc_alu #(.WIDTH(NW)) i_cc_alu (
    .clk(clk), .rst_n(rst_n), .op_a(na), .op_b(nb), .fn_code(nfn),
    .set_cc(nset), .result(nres), .illegal(nill), .zf(nzf), .sf(nsf), .of(nof));

  cc_alu #(.WIDTH(WW)) i_cc_alu_wide (
    .clk(clk), .rst_n(rst_n), .op_a(wa), .op_b(wb), .fn_code(wfn),
    .set_cc(wset), .result(wres), .illegal(will), .zf(wzf), .sf(wsf), .of(wof));

  int checks = 0;
  int errors = 0;
  logic [2:0] m_n, m_w;  // model flags {z,s,o}

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input int w, input logic [63:0] a_in, input logic [63:0] b_in,
                                input int fn, output logic [63:0] r, output logic [2:0] f);
    logic [63:0] mask, a, b;
    logic sa, sb, sr, o;
    mask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    a = a_in & mask;
    b = b_in & mask;
    case (fn)
      0: r = (b + a) & mask;
      1: r = (b - a) & mask;
      2: r = b & a;
      3: r = b ^ a;
      default: r = '0;
    endcase
    sa = a[w-1]; sb = b[w-1]; sr = r[w-1];
    o = 1'b0;
    if (fn == 0) o = (sa == sb) && (sr != sa);
    if (fn == 1) o = (sa != sb) && (sr != sb);
    f = {r == 64'd0, sr, o};
  endfunction

  function automatic string res_tag(input int fn);
    if (fn == 0) return "R1";
    if (fn == 1) return "R2";
    if (fn < 4)  return "R3";
    return "R4";
  endfunction

  task automatic vec(input logic wide, input logic [63:0] a, input logic [63:0] b,
                     input int fn, input logic set);
    logic [63:0] r, act_r;
    logic [2:0]  f, act_f, m;
    logic        act_ill;
    bit          upd;
    model(wide ? WW : NW, a, b, fn, r, f);
    @(negedge clk);
    if (wide) begin wa = a; wb = b; wfn = 4'(fn); wset = set; end
    else begin na = a[NW-1:0]; nb = b[NW-1:0]; nfn = 4'(fn); nset = set; end
    #1;
    act_r   = wide ? wres : {{(64-NW){1'b0}}, nres};
    act_ill = wide ? will : nill;
    chk(act_r == r, res_tag(fn), act_r, r);
    chk(act_ill == (fn > 3), "R4", {63'd0, act_ill}, {63'd0, fn > 3});
    upd = set && (fn < 4);
    m = wide ? m_w : m_n;
    if (upd) m = f;
    @(posedge clk);
    #1;
    act_f = wide ? {wzf, wsf, wof} : {nzf, nsf, nof};
    if (upd) begin
      chk(act_f[2] == m[2], "R5", {63'd0, act_f[2]}, {63'd0, m[2]});
      chk(act_f[1] == m[1], "R6", {63'd0, act_f[1]}, {63'd0, m[1]});
      chk(act_f[0] == m[0], "R7", {63'd0, act_f[0]}, {63'd0, m[0]});
    end else if (!set) begin
      chk(act_f == m, "R8", {61'd0, act_f}, {61'd0, m});
    end else begin
      chk(act_f == m, "R9", {61'd0, act_f}, {61'd0, m});
    end
    if (wide) m_w = m; else m_n = m;
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", WATCHDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    na = '0; nb = '0; nfn = '0; nset = 1'b0;
    wa = '0; wb = '0; wfn = '0; wset = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R10 reset state on both widths
    chk({nzf, nsf, nof} == 3'b100, "R10", {61'd0, nzf, nsf, nof}, 64'h4);
    chk({wzf, wsf, wof} == 3'b100, "R10", {61'd0, wzf, wsf, wof}, 64'h4);
    m_n = 3'b100;
    m_w = 3'b100;

    // Narrow exhaustive sweep: every operand pair, every code, update enable varied
    for (int fn = 0; fn < 16; fn++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          vec(1'b0, 64'(a), 64'(b), fn, ((a + b + fn) % 3) != 0);

    // Wide corners
    vec(1'b1, 64'd0, 64'd0, 0, 1'b1);                                   // R5 zero
    vec(1'b1, 64'd1, 64'h7fff_ffff_ffff_ffff, 0, 1'b1);                 // R7 add ovf
    vec(1'b1, 64'd5, 64'd3, 9, 1'b1);                                   // R9 hold
    vec(1'b1, 64'd1, 64'h8000_0000_0000_0000, 1, 1'b1);                 // R7 sub ovf
    vec(1'b1, 64'h8000_0000_0000_0000, 64'd0, 1, 1'b1);                 // R7 0 - min
    vec(1'b1, 64'd2, 64'd7, 1, 1'b1);                                   // R2 b - a
    vec(1'b1, 64'd0, 64'hffff_ffff_ffff_ffff, 0, 1'b0);                 // R8 hold
    vec(1'b1, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 0, 1'b1); // R6 sign
    vec(1'b1, 64'hf0f0_f0f0_f0f0_f0f0, 64'hffff_0000_ffff_0000, 2, 1'b1); // R3 and
    vec(1'b1, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 3, 1'b1); // R3 xor zero
    vec(1'b1, 64'd1, 64'd1, 15, 1'b0);                                  // R4 top code

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule